// File: doc/BRIEF.md
# Sensor SPI Frame Engine with 4-bit CRC

This block is the host side of a register link to a magnetic sensor over SPI. A client hands it one register request at a time: a read or write flag, a 7-bit register address, 16 bits of write data and a 4-bit command nibble. The engine packs these into a 32-bit frame and appends a 4-bit CRC. It shifts the frame out MSB first while it captures the 32-bit reply on SPI data in. It then returns the reply's 16 data bits together with two separate error flags.

The CRC uses the polynomial x^4 + x + 1. It starts from 4'b1111 and runs over the 28 payload bits followed by four zero bits, one bit per step for 32 steps. If the target received a corrupted frame, it spoils the CRC of its reply, so a local CRC mismatch on the reply is reported as `resp_crc_fail`. The target's own report about the previous frame travels in reply bit 31 and is returned unchanged as `resp_prev_err`.

Both client interfaces use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that cycle until the response has been taken, and a request held during that time waits. `resp_valid` and the response fields hold steady for as long as `resp_ready` stays low. The SPI clock runs at the system clock divided by `CLK_DIV` (even, at least 2). Choose `CLK_DIV` so that SCK stays at or below 10 MHz.

Top module: `sensor_spi_host`

## Requirements
- R1: The outbound frame has the read flag in bit 31 (1 = read), the address in bits 30:24, the write data in bits 23:8, the command in bits 7:4 and the CRC in bits 3:0.
- R2: The frame CRC is x^4 + x + 1 with a 4'b1111 preset, computed over bits 31:4 followed by four zero bits, MSB first.
- R3: Each frame is exactly 32 SCK cycles, MSB first, with `spi_cs_n` low for the whole frame. SCK idles low. MOSI changes only on falling SCK edges, and both sides sample on rising edges.
- R4: SCK stays in each level for `CLK_DIV/2` system clocks. The first rising edge comes `CLK_DIV/2` clocks after `spi_cs_n` falls, and `spi_cs_n` rises `CLK_DIV/2` clocks after the last falling edge.
- R5: After a frame, `spi_cs_n` stays high for `2*CLK_DIV` clocks before `resp_valid` rises, so consecutive frames are separated by at least two SCK periods.
- R6: `resp_rdata` equals reply bits 23:8.
- R7: `resp_crc_fail` is 1 exactly when the CRC of reply bits 31:4, computed as in R2, differs from reply bits 3:0.
- R8: `resp_prev_err` equals reply bit 31.
- R9: `req_ready` is low from the accepting cycle until the response handshake completes. A request presented during that time starts no frame.
- R10: While `resp_valid` is high and `resp_ready` is low, `resp_valid` and all response fields hold.
- R11: During and after reset, `spi_cs_n` is high, `spi_sck` is low, `req_ready` is high and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_read | input | 1 | 1 = register read, 0 = write |
| req_addr | input | 7 | Register address |
| req_wdata | input | 16 | Write data field |
| req_cmd | input | 4 | Command nibble |
| resp_valid | output | 1 | Response available |
| resp_ready | input | 1 | Client takes response |
| resp_rdata | output | 16 | Reply data bits 23:8 |
| resp_crc_fail | output | 1 | Reply CRC mismatch |
| resp_prev_err | output | 1 | Reply bit 31 |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Data to target |
| spi_miso | input | 1 | Data from target |

## Verification
The hardest case to reach from the ports is a reply whose CRC fails while its bit 31 is also set, combined with a request that is held valid, with different fields, during the transfer. The bench plays the target: it builds each reply with its own CRC, can invert the reply LSB and can set bit 31. It also holds `resp_ready` low for several cycles and keeps `req_valid` high through the busy window. A cycle-counting model then confirms that the waiting request never starts an extra frame and that the two error flags stay independent.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int FRAME_W   = 32;
  localparam int CRC_W     = 4;
  localparam int PAYLOAD_W = FRAME_W - CRC_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2,
    ST_RESP = 2'd3
  } sfe_state_e;

  typedef struct packed {
    logic        rd;
    logic [6:0]  addr;
    logic [15:0] data;
    logic [3:0]  cmd;
  } sfe_payload_t;
endpackage

// File: rtl/crc4_chain.sv
module crc4_chain #(
  parameter int PAYLOAD_W = 28,
  parameter int PAD_W     = 4
) (
  input  logic [PAYLOAD_W-1:0] payload,
  output logic [3:0]           crc
);
  localparam int STEPS = PAYLOAD_W + PAD_W;

  logic [STEPS-1:0] stream;
  logic [3:0]       stage [STEPS+1];

  assign stream   = {payload, {PAD_W{1'b0}}};
  assign stage[0] = 4'hF;

  for (genvar g = 0; g < STEPS; g++) begin : g_step
    logic fb;
    assign fb           = stream[STEPS-1-g] ^ stage[g][3];
    assign stage[g+1]   = {stage[g][2], stage[g][1], stage[g][0] ^ fb, fb};
  end

  assign crc = stage[STEPS];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int FRAME_W = 32,
  parameter int CLK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] tx_frame,
  input  logic               miso,
  output logic               sck,
  output logic               cs_n,
  output logic               mosi,
  output logic               done,
  output logic [FRAME_W-1:0] rx_frame
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int HCW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int EDGES = 2 * FRAME_W;
  localparam int ECW   = $clog2(EDGES + 1);

  logic               active;
  logic [HCW-1:0]     hcnt;
  logic [ECW-1:0]     ecnt;
  logic [FRAME_W-1:0] tx_sh;
  logic [FRAME_W-1:0] rx_sh;
  logic               tick;

  assign tick     = active && (hcnt == HCW'(HALF - 1));
  assign done     = tick && (ecnt == ECW'(EDGES));
  assign mosi     = tx_sh[FRAME_W-1];
  assign rx_frame = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cs_n   <= 1'b1;
      sck    <= 1'b0;
      hcnt   <= '0;
      ecnt   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      cs_n   <= 1'b0;
      sck    <= 1'b0;
      hcnt   <= '0;
      ecnt   <= '0;
      tx_sh  <= tx_frame;
    end else if (active) begin
      hcnt <= tick ? '0 : hcnt + 1'b1;
      if (tick) begin
        if (done) begin
          active <= 1'b0;
          cs_n   <= 1'b1;
        end else begin
          sck  <= ~sck;
          ecnt <= ecnt + 1'b1;
          if (!sck) rx_sh <= {rx_sh[FRAME_W-2:0], miso};
          else      tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  a_r3_sck_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  a_r3_edges_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sck) || $fell(sck)) |-> !cs_n);
  a_r3_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
endmodule

// File: rtl/sensor_spi_host.sv
module sensor_spi_host #(
  parameter int CLK_DIV     = 4,
  parameter int GAP_PERIODS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_read,
  input  logic [6:0]  req_addr,
  input  logic [15:0] req_wdata,
  input  logic [3:0]  req_cmd,
  output logic        resp_valid,
  input  logic        resp_ready,
  output logic [15:0] resp_rdata,
  output logic        resp_crc_fail,
  output logic        resp_prev_err,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  import sfe_pkg::*;

  localparam int GAP_CLKS = GAP_PERIODS * CLK_DIV;
  localparam int GCW      = $clog2(GAP_CLKS + 1);

  if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
    $error("CLK_DIV must be even and at least 2");
  end

  sfe_state_e           state;
  logic [GCW-1:0]       gcnt;
  sfe_payload_t         tx_pl;
  logic [CRC_W-1:0]     tx_crc;
  logic [CRC_W-1:0]     rx_crc;
  logic [FRAME_W-1:0]   rx_frame;
  logic                 xfer_done;
  logic                 accept;

  assign tx_pl     = '{rd: req_read, addr: req_addr, data: req_wdata, cmd: req_cmd};
  assign req_ready = (state == ST_IDLE);
  assign resp_valid = (state == ST_RESP);
  assign accept    = req_valid && req_ready;

  crc4_chain #(.PAYLOAD_W(PAYLOAD_W), .PAD_W(CRC_W)) u_tx_crc (
    .payload(tx_pl),
    .crc    (tx_crc)
  );

  crc4_chain #(.PAYLOAD_W(PAYLOAD_W), .PAD_W(CRC_W)) u_rx_crc (
    .payload(rx_frame[FRAME_W-1:CRC_W]),
    .crc    (rx_crc)
  );

  spi_shifter #(.FRAME_W(FRAME_W), .CLK_DIV(CLK_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .tx_frame({tx_pl, tx_crc}),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .done    (xfer_done),
    .rx_frame(rx_frame)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      gcnt          <= '0;
      resp_rdata    <= '0;
      resp_crc_fail <= 1'b0;
      resp_prev_err <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) state <= ST_XFER;
        ST_XFER: if (xfer_done) begin
          state         <= ST_GAP;
          gcnt          <= '0;
          resp_rdata    <= rx_frame[23:8];
          resp_crc_fail <= (rx_crc != rx_frame[CRC_W-1:0]);
          resp_prev_err <= rx_frame[FRAME_W-1];
        end
        ST_GAP: begin
          if (gcnt == GCW'(GAP_CLKS - 1)) state <= ST_RESP;
          else                            gcnt  <= gcnt + 1'b1;
        end
        ST_RESP: if (resp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r9_busy_during_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);
  a_r9_no_ready_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);
  a_r10_resp_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata)
      && $stable(resp_crc_fail) && $stable(resp_prev_err)));
  a_r5_cs_high_at_resp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> (spi_cs_n && $past(spi_cs_n)));
endmodule

// File: tb/sensor_spi_host_tb.sv
module sensor_spi_host_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 6;
  localparam int H          = CLK_DIV / 2;
  localparam int CS_LOW     = 65 * H;
  localparam int BUSY_LEN   = CS_LOW + 2 * CLK_DIV;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_read = 0, resp_ready = 0, spi_miso = 0;
  logic [6:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [3:0] req_cmd = 0;
  logic req_ready, resp_valid, resp_crc_fail, resp_prev_err, spi_sck, spi_cs_n, spi_mosi;
  logic [15:0] resp_rdata;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_spi_host #(.CLK_DIV(CLK_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata), .req_cmd(req_cmd),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
    .resp_crc_fail(resp_crc_fail), .resp_prev_err(resp_prev_err),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [3:0] ref_crc(input logic [27:0] p);
    logic [31:0] d;
    logic [3:0]  c;
    d = {p, 4'b0000};
    c = 4'hF;
    for (int i = 0; i < 32; i++) begin
      logic fb;
      fb = d[31] ^ c[3];
      c  = {c[2:0], 1'b0} ^ {2'b00, fb, fb};
      d  = d << 1;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // target model
  logic [31:0] rep = 0;
  logic [31:0] cap = 0;
  int sidx = 0, ccount = 0;
  bit in_frame = 0;
  logic [31:0] exp_frame = 0;

  always @(negedge spi_cs_n) begin
    in_frame = 1; sidx = 0; ccount = 0; cap = 0; spi_miso = rep[31];
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    sidx++;
    if (sidx < 32) spi_miso = rep[31 - sidx];
  end
  always @(posedge spi_sck) begin
    cap = {cap[30:0], spi_mosi}; ccount++;
  end
  always @(posedge spi_cs_n) if (in_frame) begin
    in_frame = 0;
    chk(cap == exp_frame, "R1/R2 frame content", cap, exp_frame);
    chk(ccount == 32, "R3 bit count", ccount, 32);
  end

  // behavioural cycle model
  int m_phase = 0, m_t = 0;
  logic [15:0] e_data; logic e_fail, e_prev;
  always @(posedge clk) begin
    if (!rst_n) m_phase = 0;
    else case (m_phase)
      0: if (req_valid && req_ready) begin
           m_phase = 1; m_t = 0;
           exp_frame[31:4] = {req_read, req_addr, req_wdata, req_cmd};
           exp_frame[3:0]  = ref_crc(exp_frame[31:4]);
           e_data = rep[23:8];
           e_fail = (ref_crc(rep[31:4]) != rep[3:0]);
           e_prev = rep[31];
         end
      1: begin m_t++; if (m_t == BUSY_LEN) m_phase = 2; end
      default: if (resp_valid && resp_ready) m_phase = 0;
    endcase
  end

  always @(negedge clk) if (rst_n) begin
    logic e_cs, e_sck;
    e_cs = 1; e_sck = 0;
    if (m_phase == 1 && m_t < CS_LOW) begin e_cs = 0; e_sck = ((m_t / H) % 2) == 1; end
    chk(spi_cs_n == e_cs, "R3/R5 cs_n", spi_cs_n, e_cs);
    chk(spi_sck == e_sck, "R4 sck", spi_sck, e_sck);
    chk(req_ready == (m_phase == 0), "R9 req_ready", req_ready, m_phase == 0);
    chk(resp_valid == (m_phase == 2), "R10 resp_valid", resp_valid, m_phase == 2);
    if (m_phase == 2) begin
      chk(resp_rdata == e_data, "R6 rdata", resp_rdata, e_data);
      chk(resp_crc_fail == e_fail, "R7 crc_fail", resp_crc_fail, e_fail);
      chk(resp_prev_err == e_prev, "R8 prev_err", resp_prev_err, e_prev);
    end
  end

  task automatic xact(input bit rd, input logic [6:0] a, input logic [15:0] d, input logic [3:0] c,
                      input logic [15:0] rdata, input bit prev, input bit bad, input int bp, input bit hold);
    logic [31:0] r;
    r[31] = prev; r[30:24] = 7'h2A ^ a; r[23:8] = rdata; r[7:4] = 4'h5 ^ c;
    r[3:0] = ref_crc(r[31:4]);
    if (bad) r[0] = ~r[0];
    rep = r;
    @(negedge clk); #1;
    req_read = rd; req_addr = a; req_wdata = d; req_cmd = c; req_valid = 1;
    @(negedge clk); #1;
    if (hold) begin
      req_addr = ~a; req_wdata = ~d; // R9: offered while busy, must wait
    end else req_valid = 0;
    while (!resp_valid) @(negedge clk);
    #1 req_valid = 0;
    repeat (bp) @(negedge clk);
    #1 resp_ready = 1;
    @(negedge clk); #1 resp_ready = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(spi_cs_n === 1'b1, "R11 cs_n reset", spi_cs_n, 1);
    chk(spi_sck === 1'b0, "R11 sck reset", spi_sck, 0);
    chk(req_ready === 1'b1, "R11 ready reset", req_ready, 1);
    chk(resp_valid === 1'b0, "R11 valid reset", resp_valid, 0);
    #1 rst_n = 1;
    xact(0, 7'h01, 16'hA55A, 4'h0, 16'h1234, 0, 0, 0, 0);
    xact(1, 7'h7F, 16'hFFFF, 4'hF, 16'hFFFF, 0, 0, 2, 0);
    xact(1, 7'h00, 16'h0000, 4'h0, 16'h0000, 0, 0, 0, 0);
    xact(0, 7'h15, 16'h8001, 4'h9, 16'hBEEF, 0, 1, 5, 0);   // R7 corrupted reply
    xact(1, 7'h40, 16'h0F0F, 4'h3, 16'h5A5A, 1, 0, 3, 0);   // R8 prev error only
    xact(1, 7'h2B, 16'h1357, 4'hC, 16'hC0DE, 1, 1, 7, 1);   // R7+R8 with R9 held request
    xact(0, 7'h55, 16'h2468, 4'h6, 16'h0001, 0, 0, 4, 1);   // R10 back-pressure, R9
    repeat (20) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule